// File: doc/BRIEF.md
# Serial Write Pointer Controller

This block is the write-side control of a serial field memory. It runs on the write clock and takes a pointer-reset pin, a write-enable pin, an input-enable pin and a 12-bit data word. It keeps a write pointer that starts in a 12-word cache region ahead of the main array. From that pointer it drives a write strobe, an address, the data and a mask bit toward a plain synchronous memory port. A word's address comes from the pointer slot claimed one edge earlier. Its commit flag comes from the input-enable level sampled at that same earlier edge.

After a pointer reset, a fixed pattern on the two enable pins during the first four edges starts a serial load of a 13-bit block number. The pin that carries the serial bits is chosen at the fifth edge. A fixed latency follows, and the pointer then lands on the start of the selected 40-word block. A block number beyond the array locks the pointer until the next pointer reset. Holding the reset and write-enable pins high for a long run puts the block into a test mode, and defined pin conditions take it out again. A status output reports the control state.

Top module: `wp_write_ctrl`

## Requirements
- R1: On the first rising edge at which `ptr_rst_i` is sampled high after being sampled low, the pointer goes to slot -12 (cache word 0), whatever `wr_en_i` is. No pointer advance happens on that edge. Status becomes ENTRY (1).
- R2: In states ENTRY and ACTIVE the pointer advances by one on each edge where `wr_en_i` is high, and it holds otherwise. A word is issued one edge later (`mem_we_o`=1 after that next edge), carrying the pointer slot claimed at the advancing edge and the `din_i` value sampled at the next edge.
- R3: `mem_mask_o` is 1 (word must not be committed) exactly when `in_en_i` was low at the edge that claimed the slot.
- R4: Block entry is recognised when, counting from the reset edge, edges 1 and 2 see `in_en_i`=0 and `wr_en_i`=1, and edges 3 and 4 see `in_en_i`=1 and `wr_en_i`=0. At edge 4 the status becomes SHIFT (2). Any mismatch drops to ACTIVE (4), and that edge is handled as a normal write edge.
- R5: At edge 5, `wr_en_i`=0 selects `din_i[0]` and `wr_en_i`=1 selects `in_en_i` as the serial pin for all 13 bits. Bits arrive MSB first, from edge 5 to edge 17, and status becomes LATENCY (3) after edge 17.
- R6: The latency lasts 18 edges (edges 18 to 35). After edge 35 the status is ACTIVE and the pointer is the block number times 40. No strobes are issued during SHIFT or LATENCY, and the pointer does not move there.
- R7: A block number of 6144 or more gives status LOCKED (5) after edge 35. In that state no strobes are issued, and only a pointer reset (R1) leaves it.
- R8: A new reset edge during ENTRY, SHIFT or LATENCY abandons the block load and acts as in R1.
- R9: Slots -12 to -1 are issued with `mem_cache_o`=1 and `mem_addr_o` equal to 0 to 11. Slots 0 to 245759 are issued with `mem_cache_o`=0 and their own address. The pointer moves from 245759 to 0.
- R10: When `ptr_rst_i` and `wr_en_i` are both high for 1024 consecutive edges, status becomes TEST (6) after the 1024th. No strobes are issued while in TEST.
- R11: TEST is left (status IDLE, 0) after an edge with `wr_en_i` low, or after the second consecutive edge with `ptr_rst_i` low. A single low edge of `ptr_rst_i` keeps TEST.
- R12: While `rst_n` is low and after it is released, status is IDLE (0) and no strobes are issued until a pointer reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial write clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| ptr_rst_i | input | 1 | Pointer reset pin; a rising level starts a new pass |
| wr_en_i | input | 1 | Write enable; advances the pointer |
| in_en_i | input | 1 | Input enable; low masks the word |
| din_i | input | 12 | Serial data word |
| mem_we_o | output | 1 | Write strobe toward the memory port |
| mem_cache_o | output | 1 | Address targets the cache region |
| mem_addr_o | output | 18 | Cache word or array address |
| mem_data_o | output | 12 | Data word to store |
| mem_mask_o | output | 1 | 1 = do not commit this word |
| status_o | output | 3 | 0 idle, 1 entry, 2 shift, 3 latency, 4 active, 5 locked, 6 test |

## Verification
The assertions check the following on every cycle:
- each strobe traces back to a write-enable two edges earlier;
- the mask matches the input-enable level at that same edge;
- cache addresses stay below 12;
- the SHIFT, LATENCY, LOCKED and TEST states issue no strobe after their first cycle.

Only the scenarios can show that:
- the serial pin choice and MSB-first order land on the right block start;
- the latency is exactly 18 edges;
- wraparound and lock recovery behave as stated;
- a repeated reset cancels a block load;
- the 1024-edge test entry and both exit conditions are timed correctly.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
   typedef enum logic [2:0] {
      WP_IDLE    = 3'd0,
      WP_ENTRY   = 3'd1,
      WP_SHIFT   = 3'd2,
      WP_LATENCY = 3'd3,
      WP_ACTIVE  = 3'd4,
      WP_LOCKED  = 3'd5,
      WP_TEST    = 3'd6
   } wp_state_e;
endpackage

// File: rtl/wp_hold_detect.sv
`timescale 1ns/1ps
// Counts consecutive edges with reset and write-enable high; owns the test flag.
module wp_hold_detect #(
   parameter int HOLD = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_rst,
   input  logic ctl_we,
   output logic enter_o,
   output logic test_o
);
   localparam int HW = $clog2(HOLD + 1);

   logic [HW-1:0] cnt_q;
   logic          test_q;
   logic          low_q;

   assign enter_o = !test_q && ctl_rst && ctl_we && (cnt_q == HW'(HOLD - 1));
   assign test_o  = test_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         test_q <= 1'b0;
         low_q  <= 1'b0;
      end else if (test_q) begin
         cnt_q <= '0;
         if (!ctl_we) begin
            test_q <= 1'b0;
            low_q  <= 1'b0;
         end else if (!ctl_rst) begin
            if (low_q) begin
               test_q <= 1'b0;
               low_q  <= 1'b0;
            end else begin
               low_q <= 1'b1;
            end
         end else begin
            low_q <= 1'b0;
         end
      end else if (enter_o) begin
         test_q <= 1'b1;
         cnt_q  <= '0;
         low_q  <= 1'b0;
      end else if (ctl_rst && ctl_we) begin
         cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end
endmodule

// File: rtl/wp_addr_loader.sv
`timescale 1ns/1ps
// Serial block-number shifter; the source pin is latched on the first bit.
module wp_addr_loader #(
   parameter int BLK_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             first,
   input  logic             ctl_we,
   input  logic             ctl_ie,
   input  logic             d0,
   output logic [BLK_W-1:0] blk_o
);
   logic sel_q;
   logic pin_sel;
   logic bit_in;

   assign pin_sel = first ? ctl_we : sel_q;
   assign bit_in  = pin_sel ? ctl_ie : d0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_o <= '0;
         sel_q <= 1'b0;
      end else if (shift_en) begin
         blk_o <= {blk_o[BLK_W-2:0], bit_in};
         if (first) sel_q <= ctl_we;
      end
   end
endmodule

// File: rtl/wp_capture.sv
`timescale 1ns/1ps
// Holds the claimed slot for one edge, then issues the word to the memory port.
module wp_capture #(
   parameter int PTR_W  = 18,
   parameter int ADDR_W = 18,
   parameter int DATA_W = 12,
   parameter int CACHE  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [PTR_W-1:0]  slot,
   input  logic              ctl_ie,
   input  logic [DATA_W-1:0] din,
   output logic              mem_we,
   output logic              mem_cache,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              mem_mask
);
   logic             cap_q;
   logic [PTR_W-1:0] slot_q;
   logic             ie_q;
   logic             in_cache;

   assign in_cache = slot_q < PTR_W'(CACHE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q     <= 1'b0;
         slot_q    <= '0;
         ie_q      <= 1'b0;
         mem_we    <= 1'b0;
         mem_cache <= 1'b0;
         mem_addr  <= '0;
         mem_data  <= '0;
         mem_mask  <= 1'b0;
      end else begin
         cap_q  <= adv;
         ie_q   <= ctl_ie;
         if (adv) slot_q <= slot;
         mem_we <= cap_q;
         if (cap_q) begin
            mem_cache <= in_cache;
            mem_addr  <= in_cache ? ADDR_W'(slot_q) : ADDR_W'(slot_q - PTR_W'(CACHE));
            mem_data  <= din;
            mem_mask  <= !ie_q;
         end
      end
   end
endmodule

// File: rtl/wp_write_ctrl.sv
`timescale 1ns/1ps
module wp_write_ctrl
   import wp_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int CACHE_WORDS = 12,
   parameter int BLOCK_WORDS = 40,
   parameter int NUM_BLOCKS  = 6144,
   parameter int BLK_W       = 13,
   parameter int LATENCY     = 18,
   parameter int TEST_HOLD   = 1024
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       ptr_rst_i,
   input  logic                                       wr_en_i,
   input  logic                                       in_en_i,
   input  logic [DATA_W-1:0]                          din_i,
   output logic                                       mem_we_o,
   output logic                                       mem_cache_o,
   output logic [$clog2(NUM_BLOCKS*BLOCK_WORDS)-1:0]  mem_addr_o,
   output logic [DATA_W-1:0]                          mem_data_o,
   output logic                                       mem_mask_o,
   output logic [2:0]                                 status_o
);
   localparam int DEPTH  = NUM_BLOCKS * BLOCK_WORDS;
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int PTR_W  = $clog2(DEPTH + CACHE_WORDS);
   localparam int LAST   = DEPTH + CACHE_WORDS - 1;
   localparam int LAT_W  = $clog2(LATENCY + 1);
   localparam int BIT_W  = $clog2(BLK_W + 1);

   if (BLK_W < 2 || (2 ** BLK_W) < NUM_BLOCKS) begin : g_bad_blk
      $error("block number width cannot hold NUM_BLOCKS");
   end
   if (CACHE_WORDS < 1 || BLOCK_WORDS < 1 || LATENCY < 1 || TEST_HOLD < 2) begin : g_bad_cfg
      $error("cache, block, latency and hold sizes must be positive");
   end

   wp_state_e        state_q, state_d;
   logic [PTR_W-1:0] ptr_q, ptr_d;
   logic [2:0]       ent_q, ent_d;
   logic [BIT_W-1:0] bit_q, bit_d;
   logic [LAT_W-1:0] lat_q, lat_d;
   logic             rst_d_q;
   logic             rise, adv, shift_en, first, pat_ok;
   logic             hold_enter, test_on;
   logic [BLK_W-1:0] blk_w;
   logic [PTR_W-1:0] blk_ptr;
   logic             blk_ok;

   assign rise   = ptr_rst_i && !rst_d_q;
   assign blk_ok = int'(blk_w) < NUM_BLOCKS;

   if ((BLOCK_WORDS & (BLOCK_WORDS - 1)) == 0) begin : g_pow2
      assign blk_ptr = PTR_W'((int'(blk_w) << $clog2(BLOCK_WORDS)) + CACHE_WORDS);
   end else begin : g_mul
      assign blk_ptr = PTR_W'(int'(blk_w) * BLOCK_WORDS + CACHE_WORDS);
   end

   wp_hold_detect #(.HOLD(TEST_HOLD)) u_hold (
      .clk(clk), .rst_n(rst_n), .ctl_rst(ptr_rst_i), .ctl_we(wr_en_i),
      .enter_o(hold_enter), .test_o(test_on)
   );

   wp_addr_loader #(.BLK_W(BLK_W)) u_load (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .first(first),
      .ctl_we(wr_en_i), .ctl_ie(in_en_i), .d0(din_i[0]), .blk_o(blk_w)
   );

   wp_capture #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CACHE(CACHE_WORDS)) u_cap (
      .clk(clk), .rst_n(rst_n), .adv(adv), .slot(ptr_q), .ctl_ie(in_en_i), .din(din_i),
      .mem_we(mem_we_o), .mem_cache(mem_cache_o), .mem_addr(mem_addr_o),
      .mem_data(mem_data_o), .mem_mask(mem_mask_o)
   );

   always_comb begin
      state_d  = state_q;
      ptr_d    = ptr_q;
      ent_d    = ent_q;
      bit_d    = bit_q;
      lat_d    = lat_q;
      adv      = 1'b0;
      shift_en = 1'b0;
      first    = 1'b0;
      pat_ok   = 1'b0;
      if (test_on || hold_enter) begin
         state_d = WP_IDLE;
      end else if (rise) begin
         ptr_d   = '0;
         state_d = WP_ENTRY;
         ent_d   = 3'd1;
      end else begin
         case (state_q)
            WP_ENTRY: begin
               pat_ok = (ent_q <= 3'd2) ? (!in_en_i && wr_en_i) : (in_en_i && !wr_en_i);
               adv    = wr_en_i;
               if (!pat_ok) begin
                  state_d = WP_ACTIVE;
               end else if (ent_q == 3'd4) begin
                  state_d = WP_SHIFT;
                  bit_d   = '0;
               end else begin
                  ent_d = ent_q + 3'd1;
               end
            end
            WP_SHIFT: begin
               shift_en = 1'b1;
               first    = (bit_q == '0);
               bit_d    = bit_q + 1'b1;
               if (bit_q == BIT_W'(BLK_W - 1)) begin
                  state_d = WP_LATENCY;
                  lat_d   = '0;
               end
            end
            WP_LATENCY: begin
               lat_d = lat_q + 1'b1;
               if (lat_q == LAT_W'(LATENCY - 1)) begin
                  if (blk_ok) begin
                     ptr_d   = blk_ptr;
                     state_d = WP_ACTIVE;
                  end else begin
                     state_d = WP_LOCKED;
                  end
               end
            end
            WP_ACTIVE: adv = wr_en_i;
            default: ;
         endcase
      end
      if (adv) ptr_d = (ptr_q == PTR_W'(LAST)) ? PTR_W'(CACHE_WORDS) : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WP_IDLE;
         ptr_q   <= '0;
         ent_q   <= '0;
         bit_q   <= '0;
         lat_q   <= '0;
         rst_d_q <= 1'b0;
      end else begin
         state_q <= state_d;
         ptr_q   <= ptr_d;
         ent_q   <= ent_d;
         bit_q   <= bit_d;
         lat_q   <= lat_d;
         rst_d_q <= ptr_rst_i;
      end
   end

   assign status_o = test_on ? WP_TEST : state_q;
endmodule

// File: rtl/wp_write_ctrl_chk.sv
`timescale 1ns/1ps
module wp_write_ctrl_chk
   import wp_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int CACHE_WORDS = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic              in_en_i,
   input logic              mem_we_o,
   input logic              mem_cache_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_mask_o,
   input logic [2:0]        status_o
);
   a_r2_strobe_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(wr_en_i, 2));

   a_r3_mask_tracks_ie: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_mask_o == !$past(in_en_i, 2)));

   a_r9_cache_range: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && mem_cache_o) |-> (mem_addr_o < ADDR_W'(CACHE_WORDS)));

   a_r6_quiet_load: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o == WP_SHIFT || status_o == WP_LATENCY) &&
       $past(status_o == WP_SHIFT || status_o == WP_LATENCY)) |-> !mem_we_o);

   a_r7_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == WP_LOCKED) |-> !mem_we_o);

   a_r10_test_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == WP_TEST && $past(status_o == WP_TEST)) |-> !mem_we_o);

   a_r12_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      status_o <= 3'd6);
endmodule

bind wp_write_ctrl wp_write_ctrl_chk #(
   .ADDR_W($clog2(NUM_BLOCKS*BLOCK_WORDS)),
   .CACHE_WORDS(CACHE_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .in_en_i(in_en_i),
   .mem_we_o(mem_we_o), .mem_cache_o(mem_cache_o), .mem_addr_o(mem_addr_o),
   .mem_mask_o(mem_mask_o), .status_o(status_o)
);

// File: tb/tb_wp_write_ctrl.sv
`timescale 1ns/1ps
module tb_wp_write_ctrl;
   localparam int DEPTH = 6144 * 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_p = 1'b0, we = 1'b0, ie = 1'b0;
   logic [11:0] din = '0;
   logic        mem_we, mem_cache, mem_mask;
   logic [17:0] mem_addr;
   logic [11:0] mem_data;
   logic [2:0]  status;

   int vectors = 0, errors = 0;
   string cur_req = "R12";
   bit done = 0;

   always #5 clk = ~clk;

   wp_write_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ptr_rst_i(rst_p), .wr_en_i(we), .in_en_i(ie), .din_i(din),
      .mem_we_o(mem_we), .mem_cache_o(mem_cache), .mem_addr_o(mem_addr),
      .mem_data_o(mem_data), .mem_mask_o(mem_mask), .status_o(status)
   );

   // behavioural reference model
   int m_state, m_ptr, m_prev, m_hold, m_test, m_low, m_ecnt, m_bcnt, m_sel, m_blk, m_lat;
   int m_cap, m_slot, m_ieq;
   int e_we, e_cache, e_mask, e_addr;
   logic [11:0] e_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_ptr = 0; m_prev = 0; m_hold = 0; m_test = 0; m_low = 0;
         m_ecnt = 0; m_bcnt = 0; m_sel = 0; m_blk = 0; m_lat = 0;
         m_cap = 0; m_slot = 0; m_ieq = 0; e_we = 0; e_cache = 0; e_mask = 0; e_addr = 0;
         e_data = '0;
      end else begin : step_model
         int rise, adv, nslot, bitv, ok;
         rise = (rst_p && !m_prev) ? 1 : 0;
         m_prev = rst_p;
         e_we = m_cap;
         if (m_cap != 0) begin
            e_cache = (m_slot < 0) ? 1 : 0;
            e_addr  = (m_slot < 0) ? m_slot + 12 : m_slot;
            e_data  = din;
            e_mask  = (m_ieq != 0) ? 0 : 1;
         end
         adv = 0;
         nslot = m_ptr;
         if (m_test != 0) begin
            m_state = 0;
            if (!we) begin m_test = 0; m_low = 0; end
            else if (!rst_p) begin
               if (m_low != 0) begin m_test = 0; m_low = 0; end else m_low = 1;
            end else m_low = 0;
         end else if (rst_p && we && m_hold == 1023) begin
            m_test = 1; m_hold = 0; m_low = 0; m_state = 0;
         end else begin
            m_hold = (rst_p && we) ? m_hold + 1 : 0;
            if (rise != 0) begin
               m_ptr = -12; m_state = 1; m_ecnt = 1;
            end else begin
               case (m_state)
                  1: begin
                     ok = (m_ecnt <= 2) ? int'(!ie && we) : int'(ie && !we);
                     adv = int'(we);
                     if (ok == 0) m_state = 4;
                     else if (m_ecnt == 4) begin m_state = 2; m_bcnt = 0; end
                     else m_ecnt++;
                  end
                  2: begin
                     if (m_bcnt == 0) m_sel = int'(we);
                     bitv = (m_sel != 0) ? int'(ie) : int'(din[0]);
                     m_blk = ((m_blk << 1) | bitv) & 8191;
                     m_bcnt++;
                     if (m_bcnt == 13) begin m_state = 3; m_lat = 0; end
                  end
                  3: begin
                     m_lat++;
                     if (m_lat == 18) begin
                        if (m_blk < 6144) begin m_ptr = m_blk * 40; m_state = 4; end
                        else m_state = 5;
                     end
                  end
                  4: adv = int'(we);
                  default: ;
               endcase
            end
         end
         if (adv != 0) m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
         m_cap = adv;
         if (adv != 0) m_slot = nslot;
         m_ieq = int'(ie);
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin : cmp
         int exp_st;
         exp_st = (m_test != 0) ? 6 : m_state;
         vectors++;
         if (int'(status) != exp_st) begin
            errors++;
            $display("FAIL %s status act=%0d exp=%0d t=%0t", cur_req, status, exp_st, $time);
         end
         vectors++;
         if (int'(mem_we) != e_we) begin
            errors++;
            $display("FAIL %s strobe act=%0d exp=%0d t=%0t", cur_req, mem_we, e_we, $time);
         end
         if (e_we != 0) begin
            vectors++;
            if (int'(mem_cache) != e_cache || int'(mem_addr) != e_addr ||
                mem_data !== e_data || int'(mem_mask) != e_mask) begin
               errors++;
               $display("FAIL %s word act=c%0d a%0d d%h m%0d exp=c%0d a%0d d%h m%0d t=%0t",
                        cur_req, mem_cache, mem_addr, mem_data, mem_mask,
                        e_cache, e_addr, e_data, e_mask, $time);
            end
         end
      end
   end

   task automatic step(input logic r, input logic w, input logic i, input logic [11:0] d);
      rst_p = r; we = w; ie = i; din = d;
      @(negedge clk);
   endtask

   task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
      vectors++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic enter_block(input int blk, input bit use_ie);
      step(1, 0, 0, 0);
      step(0, 1, 0, 0);
      step(0, 1, 0, 0);
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      chk(status == 3'd2, "R4", "status after pattern", status, 2);
      for (int b = 12; b >= 0; b--) begin
         logic bv;
         bv = logic'((blk >> b) & 1);
         if (use_ie) step(0, (b == 12) ? 1'b1 : 1'b0, bv, 12'h000);
         else step(0, 0, 0, {11'h000, bv});
      end
      chk(status == 3'd3, "R5", "status after 13 bits", status, 3);
      for (int k = 0; k < 17; k++) step(0, 0, 0, 0);
      chk(status == 3'd3, "R6", "status before last latency edge", status, 3);
      step(0, 0, 0, 0);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      chk(status == 3'd0 && !mem_we, "R12", "status in reset", status, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status == 3'd0 && !mem_we, "R12", "status after reset", status, 0);

      // normal pass with cache words, masking and gaps
      cur_req = "R1";
      step(1, 0, 0, 0);
      chk(status == 3'd1, "R1", "status after pointer reset", status, 1);
      step(0, 1, 1, 12'h100);
      step(0, 1, 1, 12'h101);
      chk(mem_we && mem_cache && mem_addr == 0 && mem_data == 12'h101, "R1", "first cache word addr", mem_addr, 0);
      cur_req = "R2";
      step(0, 0, 1, 12'h102);
      step(0, 1, 0, 12'h103);
      chk(!mem_we, "R2", "no strobe after low enable", mem_we, 0);
      cur_req = "R3";
      step(0, 1, 1, 12'h104);
      chk(mem_we && mem_mask, "R3", "masked word", mem_mask, 1);
      cur_req = "R9";
      for (int i = 0; i < 12; i++) begin
         step(0, 1, 1, 12'h200 + 12'(i));
         if (i == 9) chk(mem_we && !mem_cache && mem_addr == 0, "R9", "first array word addr", mem_addr, 0);
      end
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);

      // block entry, data-bit pin
      cur_req = "R5";
      enter_block(5, 0);
      chk(status == 3'd4, "R6", "status after latency", status, 4);
      step(0, 1, 1, 12'h000);
      step(0, 1, 1, 12'habc);
      chk(mem_we && !mem_cache && mem_addr == 200 && mem_data == 12'habc, "R5", "block 5 start", mem_addr, 200);
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);

      // block entry, enable pin, last block then wrap
      cur_req = "R9";
      enter_block(6143, 1);
      step(0, 1, 1, 12'h000);
      step(0, 1, 1, 12'h011);
      chk(mem_we && mem_addr == 245720, "R6", "last block start", mem_addr, 245720);
      for (int k = 1; k <= 42; k++) begin
         step(0, 1, 1, 12'(k));
         if (k == 40) chk(mem_we && !mem_cache && mem_addr == 0, "R9", "wrap to zero", mem_addr, 0);
      end
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);

      // invalid block locks
      cur_req = "R7";
      enter_block(7000, 0);
      chk(status == 3'd5, "R7", "locked status", status, 5);
      for (int k = 0; k < 5; k++) begin
         step(0, 1, 1, 12'h0f0);
         chk(!mem_we, "R7", "no strobe while locked", mem_we, 0);
      end
      step(0, 0, 0, 0);
      step(1, 0, 0, 0);
      chk(status == 3'd1, "R7", "reset leaves lock", status, 1);
      step(0, 0, 0, 0);

      // reset during entry and during shift cancels
      cur_req = "R8";
      step(1, 0, 0, 0);
      step(0, 1, 0, 0);
      step(1, 1, 0, 0);
      chk(status == 3'd1, "R8", "re-reset in entry", status, 1);
      step(0, 1, 1, 12'h321);
      step(0, 1, 1, 12'h322);
      chk(mem_we && mem_cache && mem_addr == 0, "R8", "pointer back at cache 0", mem_addr, 0);
      step(0, 0, 0, 0);
      step(1, 0, 0, 0);
      step(0, 1, 0, 0); step(0, 1, 0, 0); step(0, 0, 1, 0); step(0, 0, 1, 0);
      step(0, 0, 0, 1); step(0, 0, 0, 0); step(0, 0, 0, 1);
      step(1, 0, 0, 0);
      chk(status == 3'd1, "R8", "re-reset in shift", status, 1);

      // pattern mismatch
      cur_req = "R4";
      step(0, 1, 0, 0);
      step(0, 1, 1, 0);
      chk(status == 3'd4, "R4", "mismatch goes active", status, 4);
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);

      // test mode
      cur_req = "R10";
      for (int k = 0; k < 1023; k++) step(1, 1, 1, 12'h055);
      chk(status != 3'd6, "R10", "not yet test", status, 4);
      step(1, 1, 1, 12'h055);
      chk(status == 3'd6, "R10", "test entered", status, 6);
      cur_req = "R11";
      step(1, 0, 1, 0);
      chk(status == 3'd0, "R11", "exit on enable low", status, 0);
      cur_req = "R10";
      for (int k = 0; k < 1024; k++) step(1, 1, 1, 0);
      chk(status == 3'd6, "R10", "test re-entered", status, 6);
      cur_req = "R11";
      step(0, 1, 1, 0);
      chk(status == 3'd6, "R11", "one low reset keeps test", status, 6);
      step(0, 1, 1, 0);
      chk(status == 3'd0, "R11", "two low resets exit", status, 0);
      step(0, 0, 0, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule